// File: doc/BRIEF.md
# AC-link codec-side serial frame port

This block is the codec end of a bidirectional, frame-based serial audio link. A bit clock times every bit, and a SYNC pulse from the controller marks where each frame begins. A frame is 256 bits long: a 16-bit tag slot followed by twelve 20-bit slots. The controller sends frames on `sdata_out`. The block takes them apart and reads the tag to learn which slots are valid. It turns slot 1 and slot 2 into register commands for a small internal control register file. It hands the audio slots (3 to 12) to the core as raw 20-bit words.

In the other direction, the block builds one frame per SYNC period on `sdata_in`. Register reads are split across two frames. A read request in one output frame is answered in the next input frame. That answer carries the echoed register index in slot 1 and the data in slot 2. Slots 3 and 4 carry a left/right sample pair from the core. Power-down bits are only stored and read back. No converter or power sequencing hangs off them.

Top module: `aclink_codec_port`

## Requirements
- R1: A frame starts on the bit-clock cycle in which SYNC is first sampled high (sampled on the falling edge). It is 256 bits long: a 16-bit tag then twelve 20-bit slots, each sent MSB first. Output-frame bit 0 is the bit sampled with that first high SYNC. Input-frame bit 0 is driven on the next rising edge.
- R2: In every input frame after reset, tag bit 15 (codec ready) is 1.
- R3: Slot 1 of an output frame holds the command: bit 19 set means read, clear means write, and bits 18:12 give the 7-bit register index. The command is accepted only when bits 15 and 14 of that frame's tag are both set.
- R4: An accepted write takes its data from slot 2 bits 19:4, and only when tag bit 13 is also set. Only a register's writable bits change (02h: BF3Fh, 18h: 9F1Fh, 1Ah: 0707h, 20h: 2380h). All other bits keep their reset value.
- R5: In the input frame after an accepted read, tag bits 14 and 13 are set, slot 1 bits 18:12 echo the index, and slot 2 bits 19:4 carry the data. In every other input frame, those tag bits and slots 1 and 2 are zero.
- R6: Index 7Ch reads as 4359h. Its upper byte 43h is a fixed vendor identifier.
- R7: Index 00h reads as the fixed capability value 0D40h. An accepted write to 00h returns every register to its reset value.
- R8: Writes to odd or unimplemented indices change nothing. Reads of them return zero.
- R9: For each slot n from 3 to 12 of an output frame whose tag bit (15 - n) is set, the block presents the 20-bit word on `rx_pcm_data`, with n on `rx_pcm_slot`, during a one-cycle `rx_pcm_valid` pulse.
- R10: `tx_pcm_valid` is sampled at frame start. When it is high, tag bits 12 and 11 are set and slots 3 and 4 carry `tx_pcm_left` and `tx_pcm_right`. When it is low, those bits and slots are zero.
- R11: During reset, `sdata_in` and `rx_pcm_valid` are low. After reset, 02h reads 8000h, 18h reads 8808h, and the other stored registers read 0000h.
- R12: Index 26h (power-down) stores only bits 14:8 and reports them on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame sync from the controller |
| sdata_out | input | 1 | Serial data from the controller |
| sdata_in | output | 1 | Serial data to the controller |
| rx_pcm_data | output | 20 | Received audio slot word |
| rx_pcm_slot | output | 4 | Slot number of `rx_pcm_data` |
| rx_pcm_valid | output | 1 | One-cycle strobe for a received audio word |
| tx_pcm_left | input | 20 | Sample for input-frame slot 3 |
| tx_pcm_right | input | 20 | Sample for input-frame slot 4 |
| tx_pcm_valid | input | 1 | Marks the sample pair as valid |

## Verification
The assertions watch, on every cycle, the things that hold one cycle at a time:
- The frame position never leaves the tag plus twelve slots.
- Audio strobes only name slots 3 to 12.
- The ready flag leads each input frame.
- A write to an odd index leaves the stored registers as they were.
- A capability-register write puts every register back to its reset value.

Only the bench's frame scenarios can show the behaviour that spans two frames. That covers the split read answered one frame later, the write masks, and the tag gating of commands. It also covers the soft reset as seen through later reads and the bit placement of each slot on the serial line.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int TAG_BITS   = 16;
  localparam int SLOT_BITS  = 20;
  localparam int NUM_SLOTS  = 12;
  localparam int SLOT_W     = $clog2(NUM_SLOTS + 1);
  localparam int BIT_W      = $clog2(SLOT_BITS);
  localparam int IDX_W      = 7;
  localparam int DATA_W     = 16;
  localparam int FIRST_PCM  = 3;

  localparam logic [7:0] VENDOR_ID_HI = 8'h43;

  localparam int NUM_RW = 5;
  localparam logic [IDX_W-1:0]  RW_IDX  [NUM_RW] = '{7'h02, 7'h18, 7'h1A, 7'h20, 7'h26};
  localparam logic [DATA_W-1:0] RW_DEF  [NUM_RW] = '{16'h8000, 16'h8808, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [DATA_W-1:0] RW_MASK [NUM_RW] = '{16'hBF3F, 16'h9F1F, 16'h0707, 16'h2380, 16'h7F00};
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer
  import aclink_pkg::*;
(
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              sdo_i,
  output logic              start_o,
  output logic              bit_vld_o,
  output logic              slot_last_o,
  output logic              sdo_bit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o
);
  logic              smp_sync_q, smp_sdo_q;
  logic              sync_d_q, act_q, act_n;
  logic [SLOT_W-1:0] slot_q, slot_n, cur_slot;
  logic [BIT_W-1:0]  bit_q, bit_n, cur_bit;
  logic              start, vld, last;

  // falling-edge capture of the controller's lines
  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_sync_q <= 1'b0;
      smp_sdo_q  <= 1'b0;
    end else begin
      smp_sync_q <= sync_i;
      smp_sdo_q  <= sdo_i;
    end
  end

  always_comb begin
    start    = smp_sync_q & ~sync_d_q;
    vld      = start | act_q;
    cur_slot = start ? '0 : slot_q;
    cur_bit  = start ? '0 : bit_q;
    last     = (cur_slot == '0) ? (cur_bit == BIT_W'(TAG_BITS - 1))
                                : (cur_bit == BIT_W'(SLOT_BITS - 1));
    act_n    = act_q;
    slot_n   = slot_q;
    bit_n    = bit_q;
    if (vld) begin
      if (last) begin
        bit_n = '0;
        if (cur_slot == SLOT_W'(NUM_SLOTS)) begin
          act_n  = 1'b0;
          slot_n = '0;
        end else begin
          act_n  = 1'b1;
          slot_n = cur_slot + 1'b1;
        end
      end else begin
        act_n  = 1'b1;
        slot_n = cur_slot;
        bit_n  = cur_bit + 1'b1;
      end
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d_q <= 1'b0;
      act_q    <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else begin
      sync_d_q <= smp_sync_q;
      act_q    <= act_n;
      slot_q   <= slot_n;
      bit_q    <= bit_n;
    end
  end

  assign start_o     = start;
  assign bit_vld_o   = vld;
  assign slot_last_o = vld & last;
  assign sdo_bit_o   = smp_sdo_q;
  assign slot_o      = cur_slot;
  assign bit_o       = cur_bit;

  assert_frame_bounds_R1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (slot_q <= SLOT_W'(NUM_SLOTS)) && (bit_q <= BIT_W'(SLOT_BITS - 1)));
endmodule

// File: rtl/aclink_rx_decoder.sv
module aclink_rx_decoder
  import aclink_pkg::*;
(
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 bit_vld_i,
  input  logic                 slot_last_i,
  input  logic                 sdo_bit_i,
  input  logic [SLOT_W-1:0]    slot_i,
  output logic                 wr_en_o,
  output logic [IDX_W-1:0]     wr_idx_o,
  output logic [DATA_W-1:0]    wr_data_o,
  output logic                 rd_req_o,
  output logic [IDX_W-1:0]     rd_idx_o,
  output logic [SLOT_BITS-1:0] pcm_data_o,
  output logic [SLOT_W-1:0]    pcm_slot_o,
  output logic                 pcm_vld_o
);
  logic [SLOT_BITS-1:0] shift_q, word;
  logic [TAG_BITS-1:0]  tag_q;
  logic                 cmd_ok_q, cmd_rd_q;
  logic [IDX_W-1:0]     cmd_idx_q;
  logic                 at_tag, at_cmd, at_data, at_pcm;

  always_comb begin
    word    = {shift_q[SLOT_BITS-2:0], sdo_bit_i};
    at_tag  = slot_last_i && (slot_i == SLOT_W'(0));
    at_cmd  = slot_last_i && (slot_i == SLOT_W'(1));
    at_data = slot_last_i && (slot_i == SLOT_W'(2));
    at_pcm  = slot_last_i && (slot_i >= SLOT_W'(FIRST_PCM));
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q    <= '0;
      tag_q      <= '0;
      cmd_ok_q   <= 1'b0;
      cmd_rd_q   <= 1'b0;
      cmd_idx_q  <= '0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
      rd_req_o   <= 1'b0;
      rd_idx_o   <= '0;
      pcm_data_o <= '0;
      pcm_slot_o <= '0;
      pcm_vld_o  <= 1'b0;
    end else begin
      wr_en_o   <= 1'b0;
      pcm_vld_o <= 1'b0;
      if (bit_vld_i) shift_q <= word;
      if (start_i) rd_req_o <= 1'b0;
      if (at_tag) tag_q <= word[TAG_BITS-1:0];
      if (at_cmd) begin
        cmd_ok_q  <= tag_q[15] & tag_q[14];
        cmd_rd_q  <= word[19];
        cmd_idx_q <= word[18:12];
        if (tag_q[15] && tag_q[14] && word[19]) begin
          rd_req_o <= 1'b1;
          rd_idx_o <= word[18:12];
        end
      end
      if (at_data) begin
        wr_en_o   <= cmd_ok_q & ~cmd_rd_q & tag_q[13];
        wr_idx_o  <= cmd_idx_q;
        wr_data_o <= word[19:4];
      end
      if (at_pcm) begin
        pcm_vld_o  <= tag_q[4'(4'd15 - slot_i)];
        pcm_slot_o <= slot_i;
        pcm_data_o <= word;
      end
    end
  end

  assert_pcm_slot_range_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    pcm_vld_o |-> (pcm_slot_o >= SLOT_W'(FIRST_PCM)) && (pcm_slot_o <= SLOT_W'(NUM_SLOTS)));
endmodule

// File: rtl/aclink_regfile.sv
module aclink_regfile
  import aclink_pkg::*;
#(
  parameter logic [DATA_W-1:0] CAP_VAL   = 16'h0D40,
  parameter logic [7:0]        VENDOR_LO = 8'h59
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [IDX_W-1:0] CAP_IDX    = 7'h00;
  localparam logic [IDX_W-1:0] VENDOR_IDX = 7'h7C;

  logic                          soft_rst;
  logic [NUM_RW-1:0][DATA_W-1:0] store;

  assign soft_rst = wr_en_i && (wr_idx_i == CAP_IDX);

  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    logic [DATA_W-1:0] val_q, val_n;
    always_comb begin
      val_n = val_q;
      if (soft_rst)
        val_n = RW_DEF[g];
      else if (wr_en_i && (wr_idx_i == RW_IDX[g]))
        val_n = (wr_data_i & RW_MASK[g]) | (RW_DEF[g] & ~RW_MASK[g]);
    end
    always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) val_q <= RW_DEF[g];
      else        val_q <= val_n;
    end
    assign store[g] = val_q;

    assert_soft_reset_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
      soft_rst |=> (val_q == RW_DEF[g]));
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_idx_i == CAP_IDX)    rd_data_o = CAP_VAL;
    if (rd_idx_i == VENDOR_IDX) rd_data_o = {VENDOR_ID_HI, VENDOR_LO};
    for (int i = 0; i < NUM_RW; i++)
      if (rd_idx_i == RW_IDX[i]) rd_data_o = store[i];
  end

  assert_odd_write_ignored_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i[0]) |=> (store == $past(store)));
endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_pkg::*;
(
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 bit_vld_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [BIT_W-1:0]     bit_i,
  input  logic                 ready_i,
  input  logic                 rsp_vld_i,
  input  logic [IDX_W-1:0]     rsp_idx_i,
  input  logic [DATA_W-1:0]    rsp_data_i,
  input  logic                 pcm_vld_i,
  input  logic [SLOT_BITS-1:0] pcm_l_i,
  input  logic [SLOT_BITS-1:0] pcm_r_i,
  output logic                 sdi_o
);
  localparam int PAD_TAG = SLOT_BITS - TAG_BITS;
  localparam int PAD_CMD = SLOT_BITS - 1 - IDX_W;
  localparam int PAD_DAT = SLOT_BITS - DATA_W;

  logic [TAG_BITS-1:0]  tag_q, tag_n, tag_w;
  logic [SLOT_BITS-1:0] s1_q, s1_n, s1_w, s2_q, s2_n, s2_w;
  logic [SLOT_BITS-1:0] l_q, l_n, l_w, r_q, r_n, r_w, cur_word;
  logic                 sdi_n;

  always_comb begin
    tag_n = {ready_i, rsp_vld_i, rsp_vld_i, pcm_vld_i, pcm_vld_i, 11'b0};
    s1_n  = rsp_vld_i ? {1'b0, rsp_idx_i, {PAD_CMD{1'b0}}} : '0;
    s2_n  = rsp_vld_i ? {rsp_data_i, {PAD_DAT{1'b0}}} : '0;
    l_n   = pcm_vld_i ? pcm_l_i : '0;
    r_n   = pcm_vld_i ? pcm_r_i : '0;
    tag_w = start_i ? tag_n : tag_q;
    s1_w  = start_i ? s1_n  : s1_q;
    s2_w  = start_i ? s2_n  : s2_q;
    l_w   = start_i ? l_n   : l_q;
    r_w   = start_i ? r_n   : r_q;
    case (slot_i)
      SLOT_W'(0): cur_word = {tag_w, {PAD_TAG{1'b0}}};
      SLOT_W'(1): cur_word = s1_w;
      SLOT_W'(2): cur_word = s2_w;
      SLOT_W'(3): cur_word = l_w;
      SLOT_W'(4): cur_word = r_w;
      default:    cur_word = '0;
    endcase
    sdi_n = bit_vld_i ? cur_word[BIT_W'(SLOT_BITS - 1) - bit_i] : 1'b0;
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      l_q   <= '0;
      r_q   <= '0;
      sdi_o <= 1'b0;
    end else begin
      if (start_i) begin
        tag_q <= tag_n;
        s1_q  <= s1_n;
        s2_q  <= s2_n;
        l_q   <= l_n;
        r_q   <= r_n;
      end
      sdi_o <= sdi_n;
    end
  end

  assert_ready_leads_frame_R2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    start_i |=> (sdi_o == $past(ready_i)));
endmodule

// File: rtl/aclink_codec_port.sv
module aclink_codec_port
  import aclink_pkg::*;
#(
  parameter logic [DATA_W-1:0] CAP_VAL   = 16'h0D40,
  parameter logic [7:0]        VENDOR_LO = 8'h59
) (
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic                 sync,
  input  logic                 sdata_out,
  output logic                 sdata_in,
  output logic [SLOT_BITS-1:0] rx_pcm_data,
  output logic [SLOT_W-1:0]    rx_pcm_slot,
  output logic                 rx_pcm_valid,
  input  logic [SLOT_BITS-1:0] tx_pcm_left,
  input  logic [SLOT_BITS-1:0] tx_pcm_right,
  input  logic                 tx_pcm_valid
);
  logic [1:0]        rst_pipe_q;
  logic              core_rst_n, ready_q;
  logic              start, bit_vld, slot_last, sdo_bit;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bitpos;
  logic              wr_en, rd_req;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  always_ff @(posedge bit_clk or negedge core_rst_n) begin
    if (!core_rst_n) ready_q <= 1'b0;
    else             ready_q <= 1'b1;
  end

  aclink_frame_timer u_timer (
    .bit_clk(bit_clk), .rst_n(core_rst_n), .sync_i(sync), .sdo_i(sdata_out),
    .start_o(start), .bit_vld_o(bit_vld), .slot_last_o(slot_last),
    .sdo_bit_o(sdo_bit), .slot_o(slot), .bit_o(bitpos)
  );

  aclink_rx_decoder u_rx (
    .bit_clk(bit_clk), .rst_n(core_rst_n), .start_i(start), .bit_vld_i(bit_vld),
    .slot_last_i(slot_last), .sdo_bit_i(sdo_bit), .slot_i(slot),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_idx_o(rd_idx),
    .pcm_data_o(rx_pcm_data), .pcm_slot_o(rx_pcm_slot), .pcm_vld_o(rx_pcm_valid)
  );

  aclink_regfile #(.CAP_VAL(CAP_VAL), .VENDOR_LO(VENDOR_LO)) u_regs (
    .bit_clk(bit_clk), .rst_n(core_rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  aclink_tx_framer u_tx (
    .bit_clk(bit_clk), .rst_n(core_rst_n), .start_i(start), .bit_vld_i(bit_vld),
    .slot_i(slot), .bit_i(bitpos), .ready_i(ready_q),
    .rsp_vld_i(rd_req), .rsp_idx_i(rd_idx), .rsp_data_i(rd_data),
    .pcm_vld_i(tx_pcm_valid), .pcm_l_i(tx_pcm_left), .pcm_r_i(tx_pcm_right),
    .sdi_o(sdata_in)
  );
endmodule

// File: tb/aclink_codec_port_tb.sv
module aclink_codec_port_tb;
  logic        bit_clk = 1'b0;
  logic        rst_n;
  logic        sync, sdata_out, sdata_in;
  logic [19:0] rx_pcm_data, tx_pcm_left, tx_pcm_right;
  logic [3:0]  rx_pcm_slot;
  logic        rx_pcm_valid, tx_pcm_valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 bit_clk = ~bit_clk;

  aclink_codec_port u_dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .sdata_out(sdata_out),
    .sdata_in(sdata_in), .rx_pcm_data(rx_pcm_data), .rx_pcm_slot(rx_pcm_slot),
    .rx_pcm_valid(rx_pcm_valid), .tx_pcm_left(tx_pcm_left),
    .tx_pcm_right(tx_pcm_right), .tx_pcm_valid(tx_pcm_valid)
  );

  // scoreboard queues
  logic [95:0] exp_frame_q[$];
  string       exp_lbl_q[$];
  logic [23:0] exp_pcm_q[$];

  // reference model of the register file
  logic [15:0] model [128];
  bit          pend_rd = 1'b0;
  logic [6:0]  pend_idx = '0;
  string       pend_lbl = "R5";
  int          fnum = 0;

  function automatic logic [15:0] mask_of(logic [6:0] idx);
    case (idx)
      7'h02: return 16'hBF3F;
      7'h18: return 16'h9F1F;
      7'h1A: return 16'h0707;
      7'h20: return 16'h2380;
      7'h26: return 16'h7F00;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] def_of(logic [6:0] idx);
    case (idx)
      7'h02: return 16'h8000;
      7'h18: return 16'h8808;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit stored(logic [6:0] idx);
    return idx inside {7'h02, 7'h18, 7'h1A, 7'h20, 7'h26};
  endfunction

  function automatic logic [15:0] read_model(logic [6:0] idx);
    if (idx == 7'h00) return 16'h0D40;
    if (idx == 7'h7C) return 16'h4359;
    if (stored(idx))  return model[idx];
    return 16'h0000;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 128; i++) model[i] = def_of(7'(i));
  endfunction

  function automatic logic [19:0] pat(int n, int f);
    return 20'h0A000 ^ 20'(n * 9) ^ 20'(f << 8);
  endfunction

  task automatic chk(string req, string what, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: pushes expectations, then sends one 256-bit output frame
  task automatic send_frame(logic [15:0] tag, bit rd, logic [6:0] idx, logic [15:0] wdata,
                            bit pv, logic [19:0] l, logic [19:0] r, string lbl);
    logic [255:0] bits;
    logic [15:0]  etag;
    logic [19:0]  es1, es2;
    logic [19:0]  sl [3:12];
    etag = {1'b1, pend_rd, pend_rd, pv, pv, 11'b0};
    es1  = pend_rd ? {1'b0, pend_idx, 12'h000} : 20'h0;
    es2  = pend_rd ? {read_model(pend_idx), 4'h0} : 20'h0;
    exp_frame_q.push_back({etag, es1, es2, pv ? l : 20'h0, pv ? r : 20'h0});
    exp_lbl_q.push_back(pend_lbl);
    for (int n = 3; n <= 12; n++) begin
      sl[n] = pat(n, fnum);
      if (tag[15 - n]) exp_pcm_q.push_back({4'(n), sl[n]});
    end
    // model update for this frame's command
    pend_rd = tag[15] && tag[14] && rd;
    pend_idx = idx;
    pend_lbl = lbl;
    if (tag[15] && tag[14] && tag[13] && !rd) begin
      if (idx == 7'h00) model_reset();
      else if (stored(idx)) model[idx] = (wdata & mask_of(idx)) | (def_of(idx) & ~mask_of(idx));
    end
    bits = {tag, rd, idx, 12'h000, wdata, 4'h0, sl[3], sl[4], sl[5], sl[6], sl[7],
            sl[8], sl[9], sl[10], sl[11], sl[12]};
    tx_pcm_valid = pv;
    tx_pcm_left  = l;
    tx_pcm_right = r;
    for (int k = 0; k < 256; k++) begin
      @(posedge bit_clk);
      #1;
      sync      = (k < 16);
      sdata_out = bits[255 - k];
    end
    fnum++;
  endtask

  // monitor: input frames (R1 alignment, R2, R5, R10)
  initial begin
    logic [255:0] got;
    logic [95:0]  e;
    string        lbl;
    bit           prev = 1'b0;
    forever begin
      @(negedge bit_clk);
      if (sync === 1'b1 && !prev) break;
      prev = sync;
    end
    forever begin
      for (int k = 0; k < 256; k++) begin
        @(negedge bit_clk);
        got = {got[254:0], sdata_in};
      end
      if (exp_frame_q.size() > 0) begin
        e   = exp_frame_q.pop_front();
        lbl = exp_lbl_q.pop_front();
        chk("R1 R2", "tag slot", {4'h0, got[255:240]}, {4'h0, e[95:80]});
        chk(lbl, "slot1 echo", got[239:220], e[79:60]);
        chk(lbl, "slot2 data", got[219:200], e[59:40]);
        chk("R10", "slot3 left", got[199:180], e[39:20]);
        chk("R10", "slot4 right", got[179:160], e[19:0]);
      end
    end
  end

  // monitor: received audio words (R9)
  initial begin
    logic [23:0] e;
    forever begin
      @(negedge bit_clk);
      if (rst_n && rx_pcm_valid === 1'b1) begin
        if (exp_pcm_q.size() == 0) begin
          chk("R9", "unexpected strobe slot", {16'h0, rx_pcm_slot}, 20'hFFFFF);
        end else begin
          e = exp_pcm_q.pop_front();
          chk("R9", "pcm slot", {16'h0, rx_pcm_slot}, {16'h0, e[23:20]});
          chk("R9", "pcm data", rx_pcm_data, e[19:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge bit_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  localparam logic [15:0] T_RW  = 16'hE000;
  localparam logic [15:0] T_RD  = 16'hC000;
  localparam logic [15:0] T_AUD = 16'h1FF8;

  initial begin
    rst_n = 1'b0;
    sync = 1'b0;
    sdata_out = 1'b0;
    tx_pcm_valid = 1'b0;
    tx_pcm_left = '0;
    tx_pcm_right = '0;
    model_reset();
    repeat (4) @(posedge bit_clk);
    @(negedge bit_clk);
    chk("R11", "sdata_in in reset", {19'h0, sdata_in}, 20'h0);
    chk("R11", "rx_pcm_valid in reset", {19'h0, rx_pcm_valid}, 20'h0);
    @(posedge bit_clk);
    #1 rst_n = 1'b1;
    repeat (10) @(posedge bit_clk);

    send_frame(16'h0000, 0, 7'h00, 16'h0, 0, 20'h0, 20'h0, "R5");
    send_frame(T_RD,            1, 7'h02, 16'h0, 0, 20'h0, 20'h0, "R11");
    send_frame(T_RD | 16'h0A48, 1, 7'h7C, 16'h0, 1, 20'h12345, 20'hABCDE, "R6");
    send_frame(T_RD,            1, 7'h00, 16'h0, 0, 20'h0, 20'h0, "R7");
    send_frame(T_RW | T_AUD,    0, 7'h02, 16'hFFFF, 1, 20'hFFFFF, 20'h00001, "R4");
    send_frame(T_RD,            1, 7'h02, 16'h0, 0, 20'h0, 20'h0, "R4");
    send_frame(T_RW,            0, 7'h03, 16'h1234, 1, 20'h5A5A5, 20'hA5A5A, "R8");
    send_frame(T_RD,            1, 7'h03, 16'h0, 0, 20'h0, 20'h0, "R8");
    send_frame(T_RW,            0, 7'h26, 16'hFFFF, 0, 20'h0, 20'h0, "R12");
    send_frame(T_RD | 16'h1008, 1, 7'h26, 16'h0, 0, 20'h0, 20'h0, "R12");
    send_frame(T_RW,            0, 7'h40, 16'hBEEF, 0, 20'h0, 20'h0, "R8");
    send_frame(T_RD,            1, 7'h40, 16'h0, 0, 20'h0, 20'h0, "R8");
    send_frame(T_RD,            0, 7'h02, 16'h0000, 0, 20'h0, 20'h0, "R4");
    send_frame(T_RD,            1, 7'h02, 16'h0, 0, 20'h0, 20'h0, "R4");
    send_frame(16'hA000,        1, 7'h7C, 16'h0, 0, 20'h0, 20'h0, "R3");
    send_frame(T_RW,            0, 7'h1A, 16'hFFFF, 0, 20'h0, 20'h0, "R4");
    send_frame(T_RD,            1, 7'h1A, 16'h0, 0, 20'h0, 20'h0, "R4");
    send_frame(T_RW,            0, 7'h00, 16'h5555, 0, 20'h0, 20'h0, "R7");
    send_frame(T_RD,            1, 7'h02, 16'h0, 0, 20'h0, 20'h0, "R7");
    send_frame(T_RD,            1, 7'h26, 16'h0, 0, 20'h0, 20'h0, "R7");
    send_frame(T_RD,            1, 7'h18, 16'h0, 1, 20'h0F0F0, 20'h3C3C3, "R11");
    send_frame(16'h0000,        0, 7'h00, 16'h0, 0, 20'h0, 20'h0, "R5");

    repeat (6) @(posedge bit_clk);
    chk("R5", "input frames left unchecked", 20'(exp_frame_q.size()), 20'h0);
    chk("R9", "audio words not delivered", 20'(exp_pcm_q.size()), 20'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule